// File: doc/BRIEF.md
# Bidirectional GPIO Port Register Block

This block holds the control state for one general-purpose I/O port, eight pins wide by default. A small byte-wide register bus reaches three registers. The direction register makes each pin an input or an output. The output latch sets the level that an output pin drives. The pin register is read-only and returns the pad levels after a two-flop synchronizer.

Each pin sends three signals to an external pad model: a drive value, an output enable and a pull-up enable. The pull-up enable is not a register of its own. It is worked out from the direction and latch bits: a pin set as an input with a latch bit of 1 has its pull-up on. Writing ones to the pin register address does not store anything there. It inverts the matching output latch bits, so firmware can flip pins without a read-modify-write.

Register writes take effect on the clock edge where the write enable is high. Reads are combinational from the address. The reset is asynchronous and active low. Inside the block its release is brought in line with the clock.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction and latch registers read 0, and `pad_oe`, `pad_out` and `pad_pu` are all 0.
- R2: Bit n of the direction register (offset 1) sets `pad_oe[n]`. A 1 makes pin n an output, a 0 makes it an input.
- R3: `pad_out[n]` carries latch bit n (offset 2). On an output pin, 1 drives the pad high and 0 drives it low.
- R4: `pad_pu[n]` is 1 exactly when direction bit n is 0 and latch bit n is 1. `pad_pu[n]` and `pad_oe[n]` are never both 1.
- R5: A read of offset 0 returns `pad_in` through two synchronizer flops, whatever the direction bits hold. A pad change is visible in a read two clock edges later and not after one edge.
- R6: A write to offset 0 inverts latch bit n for every data bit n that is 1, and leaves the other latch bits unchanged. Nothing is stored at offset 0, so later reads of offset 0 still show the pads.
- R7: The register offsets are: pin register 0, direction register 1, latch register 2. The direction and latch registers read back the last value written to them.
- R8: Offset 3 is unmapped. It reads as 0, and a write to it changes no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write enable for the register bus |
| bus_addr | input | 2 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pad_in | input | 8 | Pad levels coming back from the pads |
| pad_out | output | 8 | Drive value for each pin |
| pad_oe | output | 8 | Output enable for each pin |
| pad_pu | output | 8 | Pull-up enable for each pin |

## Verification
A toggle write to offset 0 and a change on the pads can arrive on the same clock edge. Both touch the pin register address, but they reach different state. The bench sets up that collision by changing `pad_in` in the same cycle that it writes an inversion mask to offset 0. It then checks three things: the latch and `pad_out` are inverted after one edge; the pin register still shows the old pads after that edge; and the pin register shows the new pads, not the mask, after the second edge.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned BUS_AW = 2;
  typedef logic [BUS_AW-1:0] bus_addr_t;
  localparam bus_addr_t OFS_PIN = 2'd0;
  localparam bus_addr_t OFS_DIR = 2'd1;
  localparam bus_addr_t OFS_LAT = 2'd2;
endpackage

// File: rtl/gpio_port_rst_sync.sv
module gpio_port_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] rq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rq <= 2'b00;
    else        rq <= {rq[0], 1'b1};
  end

  assign rst_sync_n = rq[1];
endmodule

// File: rtl/gpio_port_sync.sv
module gpio_port_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned AGE_W = $clog2(STAGES + 1);

  logic [WIDTH-1:0] stg_q [STAGES];
  logic [WIDTH-1:0] stg_d [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stg_d[s] = din;
    end else begin : g_next
      assign stg_d[s] = stg_q[s-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_d[s];
    end
  end

  assign dout = stg_q[STAGES-1];

  // cycles since reset, saturating; only used to bound the latency check
  logic [AGE_W-1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     age_q <= '0;
    else if (age_q != AGE_W'(STAGES)) age_q <= age_q + 1'b1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q == AGE_W'(STAGES)) |-> (dout == $past(din, STAGES))); // R5
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  bus_addr_t        wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] lat_q
);
  logic [WIDTH-1:0] dir_d, lat_d;
  logic             dir_en, lat_en;

  always_comb begin
    dir_d  = dir_q;
    lat_d  = lat_q;
    dir_en = 1'b0;
    lat_en = 1'b0;
    if (wr_en) begin
      unique case (wr_addr)
        OFS_PIN: begin lat_d = lat_q ^ wr_data; lat_en = 1'b1; end
        OFS_DIR: begin dir_d = wr_data;         dir_en = 1'b1; end
        OFS_LAT: begin lat_d = wr_data;         lat_en = 1'b1; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= '0;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lat_q <= '0;
    else if (lat_en) lat_q <= lat_d;
  end

  AST_TOGGLE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_PIN) |=> (lat_q == ($past(lat_q) ^ $past(wr_data)))); // R6
  AST_TOGGLE_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == OFS_PIN) |=> $stable(dir_q)); // R6
  AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd3) |=> ($stable(dir_q) && $stable(lat_q))); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(dir_q) && $stable(lat_q))); // R7
endmodule

// File: rtl/gpio_port_pad_ctrl.sv
module gpio_port_pad_ctrl #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] dir,
  input  logic [WIDTH-1:0] lat,
  output logic [WIDTH-1:0] out,
  output logic [WIDTH-1:0] oe,
  output logic [WIDTH-1:0] pu
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      oe[i] = dir[i];
      out[i] = lat[i];
      pu[i] = lat[i] & ~dir[i];
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pad_pu
);
  logic             rst_i_n;
  logic [WIDTH-1:0] dir_q, lat_q, pin_s;

  gpio_port_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  gpio_port_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_i_n),
    .din   (pad_in),
    .dout  (pin_s)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (bus_we),
    .wr_addr (bus_addr),
    .wr_data (bus_wdata),
    .dir_q   (dir_q),
    .lat_q   (lat_q)
  );

  gpio_port_pad_ctrl #(.WIDTH(WIDTH)) u_pad (
    .dir (dir_q),
    .lat (lat_q),
    .out (pad_out),
    .oe  (pad_oe),
    .pu  (pad_pu)
  );

  always_comb begin
    unique case (bus_addr)
      OFS_PIN: bus_rdata = pin_s;
      OFS_DIR: bus_rdata = dir_q;
      OFS_LAT: bus_rdata = lat_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_NO_PU_ON_OUTPUT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (pad_pu & pad_oe) == '0); // R4
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_addr == 2'd3) |-> (bus_rdata == '0)); // R8
  AST_DIR_WRITE_OE: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_we && bus_addr == OFS_DIR) |=> (pad_oe == $past(bus_wdata))); // R2
  AST_LAT_WRITE_OUT: assert property (@(posedge clk) disable iff (!rst_i_n)
    (bus_we && bus_addr == OFS_LAT) |=> (pad_out == $past(bus_wdata))); // R3
endmodule

// File: tb/gpio_port_test.sv
`timescale 1ns/1ps
module gpio_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [7:0] pad_in = 8'h00;
  logic [7:0] pad_out, pad_oe, pad_pu;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(2'd1, v); check("R1 dir reset", v, 8'h00);
    rd(2'd2, v); check("R1 latch reset", v, 8'h00);
    check("R1 pad_oe reset", pad_oe, 8'h00);
    check("R1 pad_pu reset", pad_pu, 8'h00);
    check("R1 pad_out reset", pad_out, 8'h00);
  endtask

  task automatic t_dir_data;
    logic [7:0] v;
    wr(2'd1, 8'hA5);
    check("R2 pad_oe", pad_oe, 8'hA5);
    rd(2'd1, v); check("R7 dir readback", v, 8'hA5);
    wr(2'd2, 8'h3C);
    check("R3 pad_out", pad_out, 8'h3C);
    rd(2'd2, v); check("R7 latch readback", v, 8'h3C);
    check("R4 pull-up mix", pad_pu, 8'h18);
    wr(2'd1, 8'hFF);
    check("R4 pull-up off on outputs", pad_pu, 8'h00);
    wr(2'd1, 8'h00);
    check("R4 pull-up on inputs", pad_pu, 8'h3C);
  endtask

  task automatic t_toggle;
    logic [7:0] v;
    wr(2'd0, 8'h0F);
    rd(2'd2, v); check("R6 toggle result", v, 8'h33);
    check("R6 toggle on pad_out", pad_out, 8'h33);
    rd(2'd0, v); check("R6 pin reg not stored", v, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd2, v); check("R6 zero mask keeps latch", v, 8'h33);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    wr(2'd1, 8'hF0);
    @(negedge clk);
    pad_in = 8'h96;
    bus_addr = 2'd0;
    @(negedge clk);
    rd(2'd0, v); check("R5 one edge still old", v, 8'h00);
    @(negedge clk);
    rd(2'd0, v); check("R5 two edges new, any direction", v, 8'h96);
  endtask

  task automatic t_unmapped;
    logic [7:0] v;
    wr(2'd3, 8'hFF);
    rd(2'd1, v); check("R8 dir untouched", v, 8'hF0);
    rd(2'd2, v); check("R8 latch untouched", v, 8'h33);
    check("R8 pad_oe untouched", pad_oe, 8'hF0);
    rd(2'd3, v); check("R8 unmapped reads 0", v, 8'h00);
  endtask

  task automatic t_collide;
    logic [7:0] v;
    @(negedge clk);
    pad_in = 8'h5A;
    bus_addr = 2'd0; bus_wdata = 8'hFF; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    check("R6 collide latch inverted", pad_out, 8'hCC);
    rd(2'd0, v); check("R5 collide pin still old", v, 8'h96);
    @(negedge clk);
    rd(2'd0, v); check("R5 collide pin shows pads", v, 8'h5A);
  endtask

  initial begin
    #500us;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dir_data();
    t_toggle();
    t_sync();
    t_unmapped();
    t_collide();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule